// File: doc/BRIEF.md
# Line-Locked DDS Reference Generator

This block is a direct digital synthesizer that runs from a fixed 20 MHz reference clock. It produces the comparison tone for a pixel-clock PLL that is locked to the video line rate. The tone frequency is one ninth of the target pixel clock. The target pixel clock is a chosen whole multiple of the horizontal line frequency, which puts it roughly between 24.5 and 30 MHz. A 3-bit mode code picks both the multiple and the line standard. The block then uses a phase step that was computed from these when the design was built, not while it runs.

Each reference cycle, the block adds that step to a phase accumulator. It also adds a signed correction word, which a line-phase detector outside the block can drive to trim the tone. Three outputs follow from the accumulator:

- the raw phase;
- an offset-binary sine sample, meant for an external DAC and its LC filter;
- a square reference bit, taken from the top phase bit.

The DAC, the filter and the PLL are outside this block.

Top module: `line_dds_gen`

## Requirements
- R1: Reset is synchronous and active low (`rst_n` = 0 at a rising edge). After such an edge, `phase_o` is 0, `sine_o` is 128 (midscale) and `sq_o` is 0.
- R2: The mode codes map as follows: 0 gives N = 1560, 1 gives N = 1716, 2 gives N = 1732, 3 gives N = 1888 and 4 gives N = 1920. Codes 0 and 1 use a line rate fH = 15734.264 Hz; codes 2 to 4 use fH = 15625 Hz. The phase step is round(N × fH × 2^32 / (9 × 20e6)).
- R3: Codes 5, 6 and 7 are unused. Each of them produces exactly the phase step of code 1.
- R4: `corr_i` is a 16-bit two's-complement value. It is sign-extended and added to the step. At each rising edge the phase becomes phase + step(`mode_i`) + `corr_i`, using the inputs present at that edge.
- R5: The phase wraps modulo 2^32 and never saturates.
- R6: Let P be the `phase_o` value present before a rising edge, and let k = P[31:24]. After that edge, `sine_o` equals 128 + round(127 × sin(2π(k + 0.5)/256)), where rounding is symmetric about zero. The output therefore stays in 1..255, and bit 7 is set exactly when P[31] is 0.
- R7: `sq_o` always equals bit 31 of the current `phase_o`, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Pixel-multiple and line-standard selection code |
| corr_i | input | 16 | Signed phase-step correction, applied every cycle |
| phase_o | output | 32 | Phase accumulator value |
| sine_o | output | 8 | Offset-binary sine sample for the DAC |
| sq_o | output | 1 | Square reference, the phase MSB |

## Verification
A wrong step table entry, or a wrong correction sign extension, changes the difference between consecutive `phase_o` values. It therefore shows on the first clock edge that uses that mode or correction. A corrupt quarter-wave entry, or a wrong mirror or sign decision, appears on `sine_o` only one edge after the phase top byte lands on the affected address. With steps of about 38 addresses per cycle, this can take dozens of cycles, so long sweeps in two modes are run so that every address is reached. A lost wrap or a stale reset shows immediately in `phase_o` and `sq_o`.

// File: rtl/lldds_pkg.sv
package lldds_pkg;

    // Reference clock and the ratio between pixel clock and tone.
    localparam longint unsigned REF_HZ   = 64'd20000000;
    localparam longint unsigned TONE_DIV = 64'd9;

    // Line rates written as numerator / denominator in Hz.
    localparam longint unsigned FH525_NUM = 64'd15734264;
    localparam longint unsigned FH525_DEN = 64'd1000;
    localparam longint unsigned FH625_NUM = 64'd15625;
    localparam longint unsigned FH625_DEN = 64'd1;

    // Pi in Q30 fixed point.
    localparam longint PI_Q30 = 64'sd3373259426;

    typedef enum logic [2:0] {
        MODE_525_1560 = 3'd0,
        MODE_525_1716 = 3'd1,
        MODE_625_1732 = 3'd2,
        MODE_625_1888 = 3'd3,
        MODE_625_1920 = 3'd4
    } line_mode_e;

    // Pixel multiple for a code; unused codes fall back to the 1716 entry.
    function automatic int mult_of(int code);
        case (code)
            0:       return 1560;
            2:       return 1732;
            3:       return 1888;
            4:       return 1920;
            default: return 1716;
        endcase
    endfunction

    // Non-zero when a code belongs to the 625-line standard.
    function automatic bit is625_of(int code);
        return (code >= 2) && (code <= 4);
    endfunction

    // round(N * fH * 2^acc_w / (TONE_DIV * REF_HZ)).
    // Powers of two are cancelled first so that 64-bit arithmetic holds.
    function automatic longint unsigned line_step(int mult, bit is625, int acc_w);
        longint unsigned num;
        longint unsigned den;
        int              sh;
        num = longint'(mult) * (is625 ? FH625_NUM : FH525_NUM);
        den = (is625 ? FH625_DEN : FH525_DEN) * TONE_DIV * REF_HZ;
        sh  = acc_w;
        while ((sh > 0) && (den[0] == 1'b0)) begin
            den = den >> 1;
            sh  = sh - 1;
        end
        num = num << sh;
        return ((num << 1) + den) / (den << 1);
    endfunction

    function automatic longint unsigned code_step(int code, int acc_w);
        return line_step(mult_of(code), is625_of(code), acc_w);
    endfunction

    // round(amp * sin(pi * (2*idx + 1) / 2^addr_w)) by a Taylor series in Q30.
    function automatic int quarter_sine(int idx, int addr_w, int amp);
        longint x;
        longint term;
        longint acc;
        x    = (longint'(2 * idx + 1) * PI_Q30 + (longint'(1) << (addr_w - 1))) >>> addr_w;
        acc  = x;
        term = x;
        for (int k = 1; k <= 8; k++) begin
            term = -((((term * x) >>> 30) * x) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return int'((acc * longint'(amp) + (longint'(1) << 29)) >>> 30);
    endfunction

endpackage

// File: rtl/lldds_step_sel.sv
module lldds_step_sel #(
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16,
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CORR_W-1:0] corr_i,
    output logic [ACC_W-1:0]  step_o
);

    localparam int N_CODES = 2 ** MODE_W;

    logic [ACC_W-1:0] step_tab [N_CODES];
    logic [ACC_W-1:0] corr_ext;

    // One constant step per code, computed at elaboration.
    for (genvar g = 0; g < N_CODES; g++) begin : g_tab
        localparam logic [ACC_W-1:0] STEP = ACC_W'(lldds_pkg::code_step(g, ACC_W));
        assign step_tab[g] = STEP;
    end

    always_comb begin
        corr_ext = {{(ACC_W - CORR_W){corr_i[CORR_W-1]}}, corr_i};
        step_o   = step_tab[mode_i] + corr_ext;
    end

endmodule

// File: rtl/lldds_phase_acc.sv
module lldds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] phase_o
);

    logic [ACC_W-1:0] phase_q;
    logic [ACC_W-1:0] phase_d;

    always_comb begin
        phase_d = phase_q + step_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/lldds_sine_lut.sv
module lldds_sine_lut #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] phase_i,
    output logic [AMP_W-1:0] sine_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int Q_N   = 2 ** IDX_W;
    localparam int MAG_W = AMP_W - 1;
    localparam int AMP   = (2 ** MAG_W) - 1;
    localparam logic [AMP_W-1:0] MID = AMP_W'(2 ** MAG_W);

    logic [MAG_W-1:0]  qtab [Q_N];
    logic [ADDR_W-1:0] addr;
    logic [1:0]        quad;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [AMP_W-1:0]  mag;
    logic [AMP_W-1:0]  sine_d;
    logic [AMP_W-1:0]  sine_q;

    // Quarter wave sampled at half-step offsets: exact mirror and sign symmetry.
    for (genvar g = 0; g < Q_N; g++) begin : g_q
        localparam int QV = lldds_pkg::quarter_sine(g, ADDR_W, AMP);
        assign qtab[g] = MAG_W'(QV);
    end

    always_comb begin
        addr   = phase_i[ACC_W-1 -: ADDR_W];
        quad   = addr[ADDR_W-1 -: 2];
        idx    = addr[IDX_W-1:0];
        rd_idx = quad[0] ? ~idx : idx;
        mag    = {1'b0, qtab[rd_idx]};
        sine_d = quad[1] ? (MID - mag) : (MID + mag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sine_q <= MID;
        end else begin
            sine_q <= sine_d;
        end
    end

    assign sine_o = sine_q;

endmodule

// File: rtl/line_dds_gen.sv
module line_dds_gen #(
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [CORR_W-1:0] corr_i,
    output logic [ACC_W-1:0]  phase_o,
    output logic [AMP_W-1:0]  sine_o,
    output logic              sq_o
);

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase;

    lldds_step_sel #(
        .ACC_W  (ACC_W),
        .CORR_W (CORR_W),
        .MODE_W (3)
    ) u_step (
        .mode_i (mode_i),
        .corr_i (corr_i),
        .step_o (step)
    );

    lldds_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .phase_o (phase)
    );

    lldds_sine_lut #(
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_sine (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .sine_o  (sine_o)
    );

    assign phase_o = phase;
    assign sq_o    = phase[ACC_W-1];

endmodule

// File: rtl/line_dds_gen_chk.sv
module line_dds_gen_chk #(
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16,
    parameter int AMP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic [CORR_W-1:0] corr_i,
    input logic [ACC_W-1:0]  phase_o,
    input logic [AMP_W-1:0]  sine_o
);

    // Code 0 has the smallest step and code 4 the largest.
    localparam longint unsigned S_MIN = lldds_pkg::code_step(0, ACC_W);
    localparam longint unsigned S_MAX = lldds_pkg::code_step(4, ACC_W);
    localparam longint unsigned HALF  = 64'd1 << (CORR_W - 1);
    localparam logic [ACC_W-1:0] LO_STEP = ACC_W'(S_MIN - HALF);
    localparam logic [ACC_W-1:0] HI_STEP = ACC_W'(S_MAX + HALF - 64'd1);
    localparam logic [ACC_W-1:0] FB_STEP = ACC_W'(lldds_pkg::code_step(1, ACC_W));
    localparam logic [AMP_W-1:0] MID     = AMP_W'(2 ** (AMP_W - 1));

    logic was_rst_q = 1'b0;
    logic live_q    = 1'b0;

    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        live_q    <= rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (was_rst_q) begin
            reset_clear_chk: assert ((phase_o == '0) && (sine_o == MID))
                else $error("reset state not cleared");
        end
    end

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (ACC_W'(phase_o - $past(phase_o)) >= LO_STEP) &&
        (ACC_W'(phase_o - $past(phase_o)) <= HI_STEP));

    // R3
    fallback_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (($past(mode_i) >= 3'd5) && ($past(corr_i) == '0)) |->
        (ACC_W'(phase_o - $past(phase_o)) == FB_STEP));

    // R6
    sine_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        sine_o != '0);

    // R6
    sine_half_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        sine_o[AMP_W-1] == !$past(phase_o[ACC_W-1]));

endmodule

bind line_dds_gen line_dds_gen_chk #(
    .ACC_W  (ACC_W),
    .CORR_W (CORR_W),
    .AMP_W  (AMP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .corr_i  (corr_i),
    .phase_o (phase_o),
    .sine_o  (sine_o)
);

// File: tb/line_dds_gen_tb.sv
module line_dds_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd2;
    logic [15:0] corr_i = 16'd100;
    logic [31:0] phase_o;
    logic [7:0]  sine_o;
    logic        sq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    line_dds_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .corr_i  (corr_i),
        .phase_o (phase_o),
        .sine_o  (sine_o),
        .sq_o    (sq_o)
    );

    // Stimulus vectors: {mode[2:0], corr[15:0]}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 16'h0000}, {3'd1, 16'h0000}, {3'd2, 16'h0000}, {3'd3, 16'h0000},
        {3'd4, 16'h0000}, {3'd5, 16'h0000}, {3'd6, 16'h0000}, {3'd7, 16'h0000},
        {3'd1, 16'h7FFF}, {3'd1, 16'h8000}, {3'd3, 16'hFFFF}, {3'd4, 16'h04D2},
        {3'd0, 16'hFE0C}, {3'd7, 16'h012C}
    };

    function automatic logic [31:0] exp_step(logic [2:0] m);
        real n;
        real fh;
        real v;
        case (m)
            3'd0:    begin n = 1560.0; fh = 15734.264; end
            3'd2:    begin n = 1732.0; fh = 15625.0;   end
            3'd3:    begin n = 1888.0; fh = 15625.0;   end
            3'd4:    begin n = 1920.0; fh = 15625.0;   end
            default: begin n = 1716.0; fh = 15734.264; end
        endcase
        v = n * fh / 9.0 / 20.0e6 * 4294967296.0;
        return 32'($rtoi(v + 0.5));
    endfunction

    function automatic logic [7:0] exp_sine(logic [7:0] k);
        real s;
        real a;
        int  m;
        s = $sin(6.283185307179586 * (real'(k) + 0.5) / 256.0);
        a = (s < 0.0) ? -s : s;
        m = $rtoi(127.0 * a + 0.5);
        return (s < 0.0) ? 8'(128 - m) : 8'(128 + m);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Entered just after a falling edge; returns just after the next one.
    task automatic do_step(logic [2:0] m, logic [15:0] c, string req);
        logic [31:0] prev;
        logic [31:0] want;
        mode_i = m;
        corr_i = c;
        prev   = phase_o;
        @(negedge clk);
        want = prev + exp_step(m) + {{16{c[15]}}, c};
        check(req, "phase step", phase_o, want);
        if (phase_o < prev) check("R5", "wrapped phase", phase_o, want);
        check("R6", "sine sample", 32'(sine_o), 32'(exp_sine(prev[31:24])));
        check("R7", "square bit", 32'(sq_o), 32'(phase_o[31]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "phase after reset", phase_o, 32'd0);
        check("R1", "sine after reset", 32'(sine_o), 32'd128);
        check("R1", "square after reset", 32'(sq_o), 32'd0);

        rst_n = 1'b1;
        do_step(3'd0, 16'h0000, "R2");

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  vm;
            logic [15:0] vc;
            vm = VEC[i][18:16];
            vc = VEC[i][15:0];
            if (vm > 3'd4)        do_step(vm, vc, "R3");
            else if (vc != 16'h0) do_step(vm, vc, "R4");
            else                  do_step(vm, vc, "R2");
        end

        // Long sweeps so every sine address is visited (R6, R5 wraps)
        for (int i = 0; i < 600; i++) do_step(3'd4, 16'h0000, "R5");
        for (int i = 0; i < 300; i++) do_step(3'd0, 16'h0133, "R4");
        for (int i = 0; i < 50; i++)  do_step(3'd6, 16'h0000, "R3");

        // Reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "phase after mid reset", phase_o, 32'd0);
        check("R1", "sine after mid reset", 32'(sine_o), 32'd128);
        check("R1", "square after mid reset", 32'(sq_o), 32'd0);
        rst_n = 1'b1;
        do_step(3'd2, 16'h8000, "R4");
        do_step(3'd2, 16'h7FFF, "R4");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule